// File: doc/BRIEF.md
# Pixel Recolouring Stage

This block sits in a pixel-clock video path between the lane demapping of an incoming 7-bit-per-lane link and the lane mapping of the outgoing one. On every pixel clock it takes four 7-bit lane words and splits them into 8-bit red, green and blue components plus horizontal sync, vertical sync, data-enable and one spare bit. A 4-bit mode selects one colour operation. The choices are inverting all channels, one of two channel rotations, passing the pixel through, masking individual channels to zero, or overlaying eight vertical colour bars on active video. The result is packed back into four lane words.

The block has a fixed two-cycle latency. Sync, data-enable and the spare bit travel through the same pipeline without change. The colour-bar overlay measures the active width of each line by counting data-enable-high pixels. The next line is then divided into eight equal columns.

Top module: `pix_recolor`

## Requirements
- R1: Lane bit mapping (bit 0 of each lane is the first serial bit). Lane A[5:0]=R[5:0], A[6]=G[0]. Lane B[4:0]=G[5:1], B[5]=B[0], B[6]=B[1]. Lane C[3:0]=B[5:2], C[4]=hsync, C[5]=vsync, C[6]=DE. Lane D[0]=R[6], D[1]=R[7], D[2]=G[6], D[3]=G[7], D[4]=B[6], D[5]=B[7], D[6]=spare. The same mapping is used on the input and on the output.
- R2: A pixel presented before clock edge N appears on the outputs after edge N+1. Its hsync, vsync, DE and spare bit are unchanged.
- R3: Mode 4'b0000 outputs the bitwise complement of each of R, G and B.
- R4: Mode 4'b0001 outputs R=inB, G=inR, B=inG. Mode 4'b0010 outputs R=inG, G=inB, B=inR.
- R5: Modes 4'b0011, 4'b0101, 4'b0110 and 4'b0111 pass R, G and B unchanged.
- R6: When mode[3] is 1, mode[2], mode[1] and mode[0] enable R, G and B respectively. A channel that is not enabled outputs 8'h00, and an enabled channel passes unchanged.
- R7: In mode 4'b0100, pixels with DE low pass R, G and B unchanged.
- R8: In mode 4'b0100, pixels with DE high are replaced by a bar colour. Components are 8'hFF or 8'h00, and the columns run in order: white, yellow, cyan, green, magenta, red, blue, black.
- R9: The column width W is floor(P/8), where P is the number of DE-high pixels on the most recent completed line. W is treated as 1 while it is 0, which includes before any line has completed since reset. Active pixel x (counted from 0) of a line uses column min(floor(x/W), 7). Width measurement runs in every mode.
- R10: The mode is sampled together with each pixel, so a mode change affects only pixels presented after it.
- R11: While reset is high, all output lanes are zero after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Colour operation select |
| lane_a_in | input | 7 | Incoming lane A word |
| lane_b_in | input | 7 | Incoming lane B word |
| lane_c_in | input | 7 | Incoming lane C word |
| lane_d_in | input | 7 | Incoming lane D word |
| lane_a_out | output | 7 | Outgoing lane A word |
| lane_b_out | output | 7 | Outgoing lane B word |
| lane_c_out | output | 7 | Outgoing lane C word |
| lane_d_out | output | 7 | Outgoing lane D word |

## Verification
The hardest case to reach from the ports is the column boundary of the bar overlay. It depends on the active width of the line before, so it cannot be set up within a single line. The stimulus resets the block, then drives lines of 40, 43, 16 and 20 active pixels in bar mode. These lines cover the zero-width start, a width that is not a multiple of eight (so trailing pixels saturate into the black column), and a shrinking width. The bench keeps its own line-width model and predicts the colour of every pixel. A separate run switches the mode on every pixel to show that mode and pixel stay paired through the pipeline.

// File: rtl/pix_recolor_pkg.sv
package pix_recolor_pkg;

    localparam int LANE_W    = 7;
    localparam int CH_W      = 8;
    localparam int NUM_CH    = 3;
    localparam int NUM_COLS  = 8;
    localparam int COL_W     = $clog2(NUM_COLS);

    // Channel index order inside a channel array
    localparam int CH_R = 2;
    localparam int CH_G = 1;
    localparam int CH_B = 0;

    typedef logic [CH_W-1:0] chan_t;
    typedef chan_t [NUM_CH-1:0] chan_arr_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
        logic  hs;
        logic  vs;
        logic  de;
        logic  spare;
    } pix_t;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_INVERT,
        OP_ROT_BRG,
        OP_ROT_GBR,
        OP_BARS,
        OP_MASK
    } op_e;

    function automatic op_e decode_mode(input logic [3:0] m);
        op_e op;
        if (m[3]) begin
            op = OP_MASK;
        end else begin
            case (m[2:0])
                3'd0:    op = OP_INVERT;
                3'd1:    op = OP_ROT_BRG;
                3'd2:    op = OP_ROT_GBR;
                3'd4:    op = OP_BARS;
                default: op = OP_PASS;
            endcase
        end
        return op;
    endfunction

    // Column colours: white, yellow, cyan, green, magenta, red, blue, black
    function automatic logic bar_on(input logic [COL_W-1:0] col, input int ch);
        logic on;
        case (ch)
            CH_R:    on = ~col[1];
            CH_G:    on = ~col[2];
            default: on = ~col[0];
        endcase
        return on;
    endfunction

endpackage

// File: rtl/lane_unpack.sv
module lane_unpack
    import pix_recolor_pkg::*;
(
    input  logic [LANE_W-1:0] la,
    input  logic [LANE_W-1:0] lb,
    input  logic [LANE_W-1:0] lc,
    input  logic [LANE_W-1:0] ld,
    output pix_t              px
);
    always_comb begin
        px.r     = {ld[1], ld[0], la[5:0]};
        px.g     = {ld[3], ld[2], lb[4:0], la[6]};
        px.b     = {ld[5], ld[4], lc[3:0], lb[6:5]};
        px.hs    = lc[4];
        px.vs    = lc[5];
        px.de    = lc[6];
        px.spare = ld[6];
    end
endmodule

// File: rtl/lane_pack.sv
module lane_pack
    import pix_recolor_pkg::*;
(
    input  pix_t              px,
    output logic [LANE_W-1:0] la,
    output logic [LANE_W-1:0] lb,
    output logic [LANE_W-1:0] lc,
    output logic [LANE_W-1:0] ld
);
    always_comb begin
        la = {px.g[0], px.r[5:0]};
        lb = {px.b[1:0], px.g[5:1]};
        lc = {px.de, px.vs, px.hs, px.b[5:2]};
        ld = {px.spare, px.b[7:6], px.g[7:6], px.r[7:6]};
    end
endmodule

// File: rtl/bar_column.sv
module bar_column
    import pix_recolor_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de,
    output logic [COL_W-1:0] col
);
    localparam int WID_W = CNT_W - COL_W;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    logic [CNT_W-1:0] run_cnt;
    logic [WID_W-1:0] width;
    logic [WID_W-1:0] sub_cnt;
    logic [WID_W-1:0] eff_w;
    logic             de_q;

    assign eff_w = (width == '0) ? WID_W'(1) : width;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            width   <= '0;
            sub_cnt <= '0;
            col     <= '0;
            de_q    <= 1'b0;
        end else begin
            de_q <= de;
            if (de) begin
                if (run_cnt != '1) begin
                    run_cnt <= run_cnt + 1'b1;
                end
                if (col != LAST_COL) begin
                    if (sub_cnt == eff_w - 1'b1) begin
                        sub_cnt <= '0;
                        col     <= col + 1'b1;
                    end else begin
                        sub_cnt <= sub_cnt + 1'b1;
                    end
                end
            end else begin
                sub_cnt <= '0;
                col     <= '0;
                if (de_q) begin
                    width   <= run_cnt[CNT_W-1:COL_W];
                    run_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/colour_xform.sv
module colour_xform
    import pix_recolor_pkg::*;
(
    input  pix_t             px,
    input  logic [3:0]       mode,
    input  logic [COL_W-1:0] col,
    output pix_t             q
);
    chan_arr_t ch_in, ch_inv, ch_msk, ch_bar, ch_out;
    op_e       op;

    assign ch_in[CH_R] = px.r;
    assign ch_in[CH_G] = px.g;
    assign ch_in[CH_B] = px.b;
    assign op = decode_mode(mode);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        assign ch_inv[gi] = ~ch_in[gi];
        assign ch_msk[gi] = mode[gi] ? ch_in[gi] : '0;
        assign ch_bar[gi] = bar_on(col, gi) ? '1 : '0;
    end

    always_comb begin
        ch_out = ch_in;
        case (op)
            OP_INVERT:  ch_out = ch_inv;
            OP_MASK:    ch_out = ch_msk;
            OP_BARS:    if (px.de) ch_out = ch_bar;
            OP_ROT_BRG: begin
                ch_out[CH_R] = ch_in[CH_B];
                ch_out[CH_G] = ch_in[CH_R];
                ch_out[CH_B] = ch_in[CH_G];
            end
            OP_ROT_GBR: begin
                ch_out[CH_R] = ch_in[CH_G];
                ch_out[CH_G] = ch_in[CH_B];
                ch_out[CH_B] = ch_in[CH_R];
            end
            default:    ch_out = ch_in;
        endcase
        q   = px;
        q.r = ch_out[CH_R];
        q.g = ch_out[CH_G];
        q.b = ch_out[CH_B];
    end
endmodule

// File: rtl/pix_recolor.sv
module pix_recolor
    import pix_recolor_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        mode_sel,
    input  logic [LANE_W-1:0] lane_a_in,
    input  logic [LANE_W-1:0] lane_b_in,
    input  logic [LANE_W-1:0] lane_c_in,
    input  logic [LANE_W-1:0] lane_d_in,
    output logic [LANE_W-1:0] lane_a_out,
    output logic [LANE_W-1:0] lane_b_out,
    output logic [LANE_W-1:0] lane_c_out,
    output logic [LANE_W-1:0] lane_d_out
);
    pix_t             in_px, s1_px, xf_px, s2_px;
    logic [3:0]       s1_mode;
    logic [COL_W-1:0] col;

    lane_unpack u_unpack (
        .la (lane_a_in),
        .lb (lane_b_in),
        .lc (lane_c_in),
        .ld (lane_d_in),
        .px (in_px)
    );

    // Stage 1: capture pixel with its mode
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_px   <= '0;
            s1_mode <= '0;
        end else begin
            s1_px   <= in_px;
            s1_mode <= mode_sel;
        end
    end

    bar_column #(.CNT_W(CNT_W)) u_col (
        .clk (clk),
        .rst (rst),
        .de  (s1_px.de),
        .col (col)
    );

    colour_xform u_xf (
        .px   (s1_px),
        .mode (s1_mode),
        .col  (col),
        .q    (xf_px)
    );

    // Stage 2: transformed pixel
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_px <= '0;
        end else begin
            s2_px <= xf_px;
        end
    end

    lane_pack u_pack (
        .px (s2_px),
        .la (lane_a_out),
        .lb (lane_b_out),
        .lc (lane_c_out),
        .ld (lane_d_out)
    );
endmodule

// File: rtl/pix_recolor_checks.sv
module pix_recolor_checks (
    input logic       clk,
    input logic       rst,
    input logic [3:0] mode_sel,
    input logic [6:0] lane_a_in,
    input logic [6:0] lane_b_in,
    input logic [6:0] lane_c_in,
    input logic [6:0] lane_d_in,
    input logic [6:0] lane_a_out,
    input logic [6:0] lane_b_out,
    input logic [6:0] lane_c_out,
    input logic [6:0] lane_d_out
);
    logic [1:0] since_rst;
    logic       ready;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
    assign ready = (since_rst == 2'd2);

    // R2: control bits delayed two cycles, unchanged
    a_r2_ctrl_delay: assert property (@(posedge clk) disable iff (rst)
        ready |-> (lane_c_out[6:4] == $past(lane_c_in[6:4], 2)
                   && lane_d_out[6] == $past(lane_d_in[6], 2)));

    // R3: invert mode complements every colour bit
    a_r3_invert: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(mode_sel, 2) == 4'b0000) |->
        (lane_a_out == ~$past(lane_a_in, 2)
         && lane_b_out == ~$past(lane_b_in, 2)
         && lane_c_out[3:0] == ~$past(lane_c_in[3:0], 2)
         && lane_d_out[5:0] == ~$past(lane_d_in[5:0], 2)));

    // R5: pass mode reproduces the input lanes
    a_r5_pass: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(mode_sel, 2) == 4'b0011) |->
        (lane_a_out == $past(lane_a_in, 2) && lane_b_out == $past(lane_b_in, 2)
         && lane_c_out == $past(lane_c_in, 2) && lane_d_out == $past(lane_d_in, 2)));

    // R6: all channels disabled gives zero colour bits
    a_r6_all_masked: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(mode_sel, 2) == 4'b1000) |->
        (lane_a_out == 7'd0 && lane_b_out == 7'd0
         && lane_c_out[3:0] == 4'd0 && lane_d_out[5:0] == 6'd0));

    // R7: bar mode leaves blanking untouched
    a_r7_blank_pass: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(mode_sel, 2) == 4'b0100 && !$past(lane_c_in[6], 2)) |->
        (lane_a_out == $past(lane_a_in, 2) && lane_b_out == $past(lane_b_in, 2)
         && lane_c_out == $past(lane_c_in, 2) && lane_d_out == $past(lane_d_in, 2)));
endmodule

bind pix_recolor pix_recolor_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .lane_a_in  (lane_a_in),
    .lane_b_in  (lane_b_in),
    .lane_c_in  (lane_c_in),
    .lane_d_in  (lane_d_in),
    .lane_a_out (lane_a_out),
    .lane_b_out (lane_b_out),
    .lane_c_out (lane_c_out),
    .lane_d_out (lane_d_out)
);

// File: tb/pix_recolor_test.sv
module pix_recolor_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mode_sel = 4'd0;
    logic [6:0] lane_a_in = '0, lane_b_in = '0, lane_c_in = '0, lane_d_in = '0;
    logic [6:0] lane_a_out, lane_b_out, lane_c_out, lane_d_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [27:0] lanes;
        int          due;
        string       tag;
    } item_t;
    item_t sbq[$];

    // Bench-side line-width model
    int m_run, m_width, m_x;
    bit m_deq;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pix_recolor uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .lane_a_in(lane_a_in), .lane_b_in(lane_b_in),
        .lane_c_in(lane_c_in), .lane_d_in(lane_d_in),
        .lane_a_out(lane_a_out), .lane_b_out(lane_b_out),
        .lane_c_out(lane_c_out), .lane_d_out(lane_d_out)
    );

    // R1 lane mapping, written from the requirement
    function automatic logic [27:0] pack(input logic [7:0] r, g, b,
                                         input logic hs, vs, de, sp);
        logic [6:0] a, bb, c, d;
        a  = {g[0], r[5:0]};
        bb = {b[1:0], g[5:1]};
        c  = {de, vs, hs, b[5:2]};
        d  = {sp, b[7:6], g[7:6], r[7:6]};
        return {a, bb, c, d};
    endfunction

    localparam logic [27:0] COLOUR_MASK = {7'h7f, 7'h7f, 7'h0f, 7'h3f};

    task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %07h expected %07h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [7:0] r, g, b, input logic hs, vs, de, sp,
                         input logic [3:0] md, input string tag);
        logic [7:0] er, eg, eb;
        logic [27:0] lv;
        int w, col;
        item_t it;
        @(negedge clk);
        lv = pack(r, g, b, hs, vs, de, sp);
        {lane_a_in, lane_b_in, lane_c_in, lane_d_in} = lv;
        mode_sel = md;
        // R9 column model
        w = (m_width == 0) ? 1 : m_width;
        col = m_x / w;
        if (col > 7) col = 7;
        er = r; eg = g; eb = b;
        case (md)
            4'b0000: begin er = ~r; eg = ~g; eb = ~b; end
            4'b0001: begin er = b; eg = r; eb = g; end
            4'b0010: begin er = g; eg = b; eb = r; end
            4'b0100: if (de) begin
                case (col)
                    0: {er, eg, eb} = {8'hFF, 8'hFF, 8'hFF};
                    1: {er, eg, eb} = {8'hFF, 8'hFF, 8'h00};
                    2: {er, eg, eb} = {8'h00, 8'hFF, 8'hFF};
                    3: {er, eg, eb} = {8'h00, 8'hFF, 8'h00};
                    4: {er, eg, eb} = {8'hFF, 8'h00, 8'hFF};
                    5: {er, eg, eb} = {8'hFF, 8'h00, 8'h00};
                    6: {er, eg, eb} = {8'h00, 8'h00, 8'hFF};
                    default: {er, eg, eb} = 24'h0;
                endcase
            end
            default: if (md[3]) begin
                er = md[2] ? r : 8'h00;
                eg = md[1] ? g : 8'h00;
                eb = md[0] ? b : 8'h00;
            end
        endcase
        if (de) begin
            m_x++;
            m_run++;
        end else begin
            m_x = 0;
            if (m_deq) begin
                m_width = m_run / 8;
                m_run = 0;
            end
        end
        m_deq = de;
        it.lanes = pack(er, eg, eb, hs, vs, de, sp);
        it.due = cyc + 2;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t it;
            logic [27:0] act;
            it = sbq.pop_front();
            act = {lane_a_out, lane_b_out, lane_c_out, lane_d_out};
            check(it.tag, act & COLOUR_MASK, it.lanes & COLOUR_MASK);
            check("R2 control bits", act & ~COLOUR_MASK, it.lanes & ~COLOUR_MASK);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {lane_a_in, lane_b_in, lane_c_in, lane_d_in} = '1;
        mode_sel = 4'b0011;
        repeat (2) @(negedge clk);
        check("R11 reset outputs", {lane_a_out, lane_b_out, lane_c_out, lane_d_out}, 28'h0);
        m_run = 0; m_width = 0; m_x = 0; m_deq = 0;
        rst = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic bar_line(input int active);
        for (int i = 0; i < 5; i++)
            drive(8'($urandom), 8'($urandom), 8'($urandom), 1'b1, 1'b0, 1'b0, 1'b1, 4'b0100, "R7 blanking");
        for (int i = 0; i < active; i++)
            drive(8'($urandom), 8'($urandom), 8'($urandom), 1'b0, 1'b0, 1'b1, 1'b0, 4'b0100, "R8 R9 bar colour");
    endtask

    function automatic string mode_tag(input logic [3:0] md);
        if (md == 4'b0000) return "R3 invert";
        if (md == 4'b0001 || md == 4'b0010) return "R4 rotate";
        if (md[3]) return "R6 mask";
        return "R5 R1 pass";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // Every non-bar mode, several pixels each
        for (int m = 0; m < 16; m++) begin
            if (m == 4) continue;
            for (int k = 0; k < 6; k++)
                drive(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 4'(m), mode_tag(4'(m)));
        end
        // Corner values
        drive(8'h00, 8'hFF, 8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, "R3 invert");
        drive(8'h01, 8'h02, 8'h04, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0001, "R4 rotate");
        drive(8'h01, 8'h02, 8'h04, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0010, "R4 rotate");
        // Mode changes on every pixel
        for (int k = 0; k < 32; k++)
            drive(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 4'($urandom), "R10 per-pixel mode");
        drain();

        // Bar overlay from a fresh reset: zero width, non-multiple width, shrinking width
        do_reset();
        bar_line(40);
        bar_line(43);
        bar_line(16);
        bar_line(20);
        for (int i = 0; i < 4; i++)
            drive(8'h12, 8'h34, 8'h56, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0100, "R7 blanking");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule